// File: doc/BRIEF.md
# Dual-Core Boot Strap and Hold Controller

This block sequences the start of a system with two processor cores, called core A and core B. Reset is released, and the block then counts clock edges. On a fixed edge it samples the boot-mode pin, the four per-core boot-address words, the protection flag and the two per-core boot-enable bits. From these it computes, once, a fetch address for each core and decides which core gets its clock and comes out of reset. The other core stays gated.

Each core has two programmable boot words, and the sampled pin picks one of them. A word that points outside the valid memory regions is replaced by a fixed default for that core and pin value. When the high protection level is active, only flash or system-memory words are kept. Any other word becomes the core's flash default. A core that starts gated stays gated until a hold-release request arrives after the latch. Such a request is sticky until the next reset. A core's run signal rises one cycle after its clock enable, so the clock is running before the core leaves reset.

Top module: `dual_boot_ctrl`

## Requirements
- R1: The boot pin and the other strap inputs are captured on exactly the 4th rising clock edge after `rst_n` goes high. The pin level on edges 1 to 3 and after edge 4 has no effect.
- R2: If no protection is active, pin 0 selects the core's word 0 and pin 1 selects word 1. A selected word that lies in a valid region is output unchanged.
- R3: If no protection is active, a selected word outside every valid region is replaced by a default. For pin 0 the defaults are 0x0800_0000 for A and 0x0810_0000 for B. For pin 1 they are 0x1FF0_0000 for A and 0x1000_0000 for B. The valid regions have inclusive limits:
  - ITCM 0x0000_0000–0x0000_FFFF
  - flash 0x0800_0000–0x081F_FFFF
  - SRAM alias 0x1000_0000–0x1004_7FFF
  - system memory 0x1FF0_0000–0x1FF1_FFFF
  - DTCM 0x2000_0000–0x2001_FFFF
  - AXI SRAM 0x2400_0000–0x2407_FFFF
  - SRAM 0x3000_0000–0x3004_7FFF
  - SRAM4 0x3800_0000–0x3800_FFFF
  
  Nothing above 0x3FFF_FFFF is valid.
- R4: If `prot_high`=1, a selected word in the flash or system-memory region is kept. Any other selected word is replaced by 0x0800_0000 for A and 0x0810_0000 for B, whatever the pin.
- R5: The enable bits (`boot_en_a`, `boot_en_b`) decide which clocks start at the latch. (0,0) and (1,0) start A only. (0,1) starts B only. (1,1) starts both.
- R6: A gated core's clock enable rises on the edge after `hold_rel_x` is seen high. Only requests seen after the latch edge count. Once set, the enable stays high until reset.
- R7: `core_run_x` rises exactly one cycle after `core_clk_en_x` rises. It is never high while the clock enable is low.
- R8: Boot addresses do not change from the latch until the next reset, whatever the inputs do.
- R9: Before the latch, both clock enables, both run signals and both addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_pin | input | 1 | Boot-mode strap pin |
| prot_high | input | 1 | High protection level active |
| boot_en_a | input | 1 | Boot-enable bit of core A |
| boot_en_b | input | 1 | Boot-enable bit of core B |
| opt_addr_a0 | input | 32 | Core A boot word for pin 0 |
| opt_addr_a1 | input | 32 | Core A boot word for pin 1 |
| opt_addr_b0 | input | 32 | Core B boot word for pin 0 |
| opt_addr_b1 | input | 32 | Core B boot word for pin 1 |
| hold_rel_a | input | 1 | Request to release held core A |
| hold_rel_b | input | 1 | Request to release held core B |
| boot_addr_a | output | 32 | Fetch address of core A |
| boot_addr_b | output | 32 | Fetch address of core B |
| core_clk_en_a | output | 1 | Clock enable of core A |
| core_clk_en_b | output | 1 | Clock enable of core B |
| core_run_a | output | 1 | Reset release of core A |
| core_run_b | output | 1 | Reset release of core B |

## Verification
The bench holds the pin at the opposite level on edges 1 to 3 and after edge 4. A sampler that is off by one edge therefore latches the wrong mode and returns the other boot word. Words are placed exactly on region bases and limits, one step beyond them, and above the address ceiling. A wrong comparison then keeps an invalid word or replaces a valid one with a default. Hold-release requests are raised before the latch and must be lost. A design that records them early would start the held core without permission. After the latch the bench scrambles every strap input and checks that the addresses stay put. It also checks the one-cycle gap between clock enable and run.

// File: rtl/boot_pkg.sv
package boot_pkg;

  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned N_REGION = 8;

  // Highest address a boot word may name.
  localparam logic [ADDR_W-1:0] ADDR_CEIL = 32'h3FFF_FFFF;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic              is_ram;
  } region_t;

  typedef region_t [N_REGION-1:0] region_tab_t;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_CODE = 2'd1,
    K_RAM  = 2'd2
  } kind_t;

  // Memory map, index 7 down to 0. Limits are inclusive.
  localparam region_tab_t DEFAULT_MAP = '{
    '{base: 32'h3800_0000, limit: 32'h3800_FFFF, is_ram: 1'b1},  // SRAM4
    '{base: 32'h3000_0000, limit: 32'h3004_7FFF, is_ram: 1'b1},  // SRAM1..3
    '{base: 32'h2400_0000, limit: 32'h2407_FFFF, is_ram: 1'b1},  // AXI SRAM
    '{base: 32'h2000_0000, limit: 32'h2001_FFFF, is_ram: 1'b1},  // DTCM
    '{base: 32'h1FF0_0000, limit: 32'h1FF1_FFFF, is_ram: 1'b0},  // system memory
    '{base: 32'h1000_0000, limit: 32'h1004_7FFF, is_ram: 1'b1},  // SRAM alias
    '{base: 32'h0800_0000, limit: 32'h081F_FFFF, is_ram: 1'b0},  // flash
    '{base: 32'h0000_0000, limit: 32'h0000_FFFF, is_ram: 1'b1}   // ITCM
  };

  // Classify an address against the region table.
  function automatic kind_t addr_kind(input logic [ADDR_W-1:0] a,
                                      input region_tab_t t);
    kind_t k;
    k = K_NONE;
    if (a <= ADDR_CEIL) begin
      for (int i = 0; i < N_REGION; i++) begin
        if (a >= t[i].base && a <= t[i].limit)
          k = t[i].is_ram ? K_RAM : K_CODE;
      end
    end
    return k;
  endfunction

  // Choose a core's fetch address from its two boot words.
  function automatic logic [ADDR_W-1:0] pick_addr(
      input logic [ADDR_W-1:0] w0,
      input logic [ADDR_W-1:0] w1,
      input logic              pin,
      input logic              prot,
      input logic [ADDR_W-1:0] dflt0,
      input logic [ADDR_W-1:0] dflt1,
      input logic [ADDR_W-1:0] dflt_flash,
      input region_tab_t       t);
    logic [ADDR_W-1:0] cand;
    kind_t k;
    cand = pin ? w1 : w0;
    k    = addr_kind(cand, t);
    if (prot)
      return (k == K_CODE) ? cand : dflt_flash;
    else
      return (k == K_NONE) ? (pin ? dflt1 : dflt0) : cand;
  endfunction

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch #(
  parameter int unsigned LATCH_EDGE = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic capture_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(LATCH_EDGE + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  // Strap capture happens on the edge that ends the count.
  assign capture_o = !done_q && (cnt_q == CNT_W'(LATCH_EDGE - 1));
  assign done_o    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (capture_o) done_q <= 1'b1;
    end
  end

  a_r1_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  a_r1_capture_once: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |=> (!capture_o && done_q));

endmodule

// File: rtl/boot_addr_sel.sv
module boot_addr_sel
  import boot_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DFLT0      = 32'h0800_0000,
  parameter logic [ADDR_W-1:0] DFLT1      = 32'h1FF0_0000,
  parameter logic [ADDR_W-1:0] DFLT_FLASH = 32'h0800_0000,
  parameter region_tab_t       MAP        = DEFAULT_MAP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              pin_i,
  input  logic              prot_i,
  input  logic [ADDR_W-1:0] word0_i,
  input  logic [ADDR_W-1:0] word1_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_next;

  assign addr_next = pick_addr(word0_i, word1_i, pin_i, prot_i,
                               DFLT0, DFLT1, DFLT_FLASH, MAP);
  assign addr_o    = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (capture_i) addr_q <= addr_next;
  end

  a_r8_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(addr_q));
  a_r4_prot_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && prot_i) |=> (addr_kind(addr_q, MAP) == K_CODE));
  a_r3_result_mapped: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> (addr_kind(addr_q, MAP) != K_NONE));

endmodule

// File: rtl/core_hold_ctrl.sv
module core_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_i,
  input  logic done_i,
  input  logic boot_i,
  input  logic release_i,
  output logic clk_en_o,
  output logic run_o
);
  logic clk_en_q;
  logic run_q;

  assign clk_en_o = clk_en_q;
  assign run_o    = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en_q <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      if (capture_i)              clk_en_q <= boot_i;
      else if (done_i && release_i) clk_en_q <= 1'b1;
      run_q <= clk_en_q;
    end
  end

  a_r6_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_q |=> clk_en_q);
  a_r7_run_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> clk_en_q);
  a_r7_run_lags_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en_q) |-> (!run_q ##1 run_q));

endmodule

// File: rtl/dual_boot_ctrl.sv
module dual_boot_ctrl
  import boot_pkg::*;
#(
  parameter int unsigned       LATCH_EDGE = 4,
  parameter logic [ADDR_W-1:0] DFLT_A0    = 32'h0800_0000,
  parameter logic [ADDR_W-1:0] DFLT_A1    = 32'h1FF0_0000,
  parameter logic [ADDR_W-1:0] DFLT_B0    = 32'h0810_0000,
  parameter logic [ADDR_W-1:0] DFLT_B1    = 32'h1000_0000,
  parameter region_tab_t       MAP        = DEFAULT_MAP
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_pin,
  input  logic        prot_high,
  input  logic        boot_en_a,
  input  logic        boot_en_b,
  input  logic [31:0] opt_addr_a0,
  input  logic [31:0] opt_addr_a1,
  input  logic [31:0] opt_addr_b0,
  input  logic [31:0] opt_addr_b1,
  input  logic        hold_rel_a,
  input  logic        hold_rel_b,
  output logic [31:0] boot_addr_a,
  output logic [31:0] boot_addr_b,
  output logic        core_clk_en_a,
  output logic        core_clk_en_b,
  output logic        core_run_a,
  output logic        core_run_b
);
  localparam int unsigned N_CORE = 2;

  logic capture;
  logic done;

  logic [ADDR_W-1:0] word0_v [N_CORE];
  logic [ADDR_W-1:0] word1_v [N_CORE];
  logic [ADDR_W-1:0] addr_v  [N_CORE];
  logic [N_CORE-1:0] boot_v;
  logic [N_CORE-1:0] rel_v;
  logic [N_CORE-1:0] clk_en_v;
  logic [N_CORE-1:0] run_v;

  assign word0_v[0] = opt_addr_a0;
  assign word1_v[0] = opt_addr_a1;
  assign word0_v[1] = opt_addr_b0;
  assign word1_v[1] = opt_addr_b1;

  // Core A starts unless B alone is enabled; B starts when its bit is set.
  assign boot_v[0] = boot_en_a | ~boot_en_b;
  assign boot_v[1] = boot_en_b;
  assign rel_v     = {hold_rel_b, hold_rel_a};

  boot_strap_latch #(.LATCH_EDGE(LATCH_EDGE)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_o (capture),
    .done_o    (done)
  );

  for (genvar g = 0; g < N_CORE; g++) begin : g_core
    localparam logic [ADDR_W-1:0] D0 = (g == 0) ? DFLT_A0 : DFLT_B0;
    localparam logic [ADDR_W-1:0] D1 = (g == 0) ? DFLT_A1 : DFLT_B1;

    boot_addr_sel #(
      .DFLT0      (D0),
      .DFLT1      (D1),
      .DFLT_FLASH (D0),
      .MAP        (MAP)
    ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture),
      .pin_i     (boot_pin),
      .prot_i    (prot_high),
      .word0_i   (word0_v[g]),
      .word1_i   (word1_v[g]),
      .addr_o    (addr_v[g])
    );

    core_hold_ctrl u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture),
      .done_i    (done),
      .boot_i    (boot_v[g]),
      .release_i (rel_v[g]),
      .clk_en_o  (clk_en_v[g]),
      .run_o     (run_v[g])
    );
  end

  assign boot_addr_a   = addr_v[0];
  assign boot_addr_b   = addr_v[1];
  assign core_clk_en_a = clk_en_v[0];
  assign core_clk_en_b = clk_en_v[1];
  assign core_run_a    = run_v[0];
  assign core_run_b    = run_v[1];

  a_r9_quiet_before_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (clk_en_v == '0 && run_v == '0 &&
               addr_v[0] == '0 && addr_v[1] == '0));
  a_r5_some_core_runs: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (clk_en_v != '0));

endmodule

// File: tb/test_dual_boot_ctrl.sv
module test_dual_boot_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_pin = 1'b0, prot_high = 1'b0, boot_en_a = 1'b0, boot_en_b = 1'b0;
  logic [31:0] opt_addr_a0 = '0, opt_addr_a1 = '0, opt_addr_b0 = '0, opt_addr_b1 = '0;
  logic        hold_rel_a = 1'b0, hold_rel_b = 1'b0;
  logic [31:0] boot_addr_a, boot_addr_b;
  logic        core_clk_en_a, core_clk_en_b, core_run_a, core_run_b;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;  // 250 MHz

  dual_boot_ctrl i_dual_boot_ctrl (.*);

  // Region list written out again in the bench: base, last byte, ram flag.
  logic [31:0] rb [8] = '{32'h0000_0000, 32'h0800_0000, 32'h1000_0000, 32'h1FF0_0000,
                          32'h2000_0000, 32'h2400_0000, 32'h3000_0000, 32'h3800_0000};
  logic [31:0] rl [8] = '{32'h0000_FFFF, 32'h081F_FFFF, 32'h1004_7FFF, 32'h1FF1_FFFF,
                          32'h2001_FFFF, 32'h2407_FFFF, 32'h3004_7FFF, 32'h3800_FFFF};
  bit          rr [8] = '{1, 0, 1, 0, 1, 1, 1, 1};

  // 0 = unmapped, 1 = flash/system, 2 = RAM
  function automatic int kind_of(logic [31:0] a);
    for (int i = 0; i < 8; i++)
      if (a >= rb[i] && a <= rl[i]) return rr[i] ? 2 : 1;
    return 0;
  endfunction

  function automatic logic [31:0] exp_addr(bit core_b, bit p, bit prot,
                                           logic [31:0] w0, logic [31:0] w1);
    logic [31:0] c, flash_def, slot_def;
    c         = p ? w1 : w0;
    flash_def = core_b ? 32'h0810_0000 : 32'h0800_0000;
    if (!p) slot_def = flash_def;
    else    slot_def = core_b ? 32'h1000_0000 : 32'h1FF0_0000;
    if (prot) return (kind_of(c) == 1) ? c : flash_def;
    return (kind_of(c) == 0) ? slot_def : c;
  endfunction

  function automatic string addr_req(bit p, bit prot, logic [31:0] w0, logic [31:0] w1);
    if (prot) return "R4";
    if (kind_of(p ? w1 : w0) == 0) return "R3";
    return "R2";
  endfunction

  function automatic logic [31:0] rand_addr();
    int r = $urandom_range(0, 7);
    case ($urandom_range(0, 5))
      0: return rb[r] + ($urandom % (rl[r] - rb[r] + 1));
      1: return rl[r] + 32'd1;
      2: return rb[r] - 32'd1;
      3: return rl[r];
      4: return $urandom & 32'h3FFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic trial(bit p, bit prot, bit ea, bit eb,
                       logic [31:0] a0, logic [31:0] a1,
                       logic [31:0] b0, logic [31:0] b1);
    logic [31:0] xa, xb;
    bit ba, bb;
    xa = exp_addr(0, p, prot, a0, a1);
    xb = exp_addr(1, p, prot, b0, b1);
    ba = ea | ~eb;
    bb = eb;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    prot_high = prot; boot_en_a = ea; boot_en_b = eb;
    opt_addr_a0 = a0; opt_addr_a1 = a1; opt_addr_b0 = b0; opt_addr_b1 = b1;
    boot_pin = ~p; hold_rel_a = 1'b1; hold_rel_b = 1'b1;  // early requests must be lost (R6)
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: three edges after reset, nothing has started yet
    chk("R9", {core_clk_en_a, core_clk_en_b, core_run_a, core_run_b}, 32'd0);
    chk("R9", boot_addr_a | boot_addr_b, 32'd0);
    boot_pin = p; hold_rel_a = 1'b0; hold_rel_b = 1'b0;
    @(negedge clk);  // 4th edge done
    boot_pin = ~p; prot_high = ~prot; boot_en_a = ~ea; boot_en_b = ~eb;
    opt_addr_a0 = $urandom; opt_addr_a1 = $urandom;
    opt_addr_b0 = $urandom; opt_addr_b1 = $urandom;
    // R1 with R2/R3/R4: the edge-4 pin picks the word
    chk(addr_req(p, prot, a0, a1), boot_addr_a, xa);
    chk(addr_req(p, prot, b0, b1), boot_addr_b, xb);
    chk("R5", {core_clk_en_a, core_clk_en_b}, {ba, bb});
    chk("R7", {core_run_a, core_run_b}, 32'd0);
    @(negedge clk);
    chk("R7", {core_run_a, core_run_b}, {ba, bb});
    chk("R8", boot_addr_a, xa);
    chk("R8", boot_addr_b, xb);
    repeat (2) @(negedge clk);
    chk("R6", {core_clk_en_a, core_clk_en_b}, {ba, bb});
    if (!(ba && bb)) begin
      // requester core's own release line: no effect on the held core
      if (ba) hold_rel_a = 1'b1; else hold_rel_b = 1'b1;
      @(negedge clk);
      hold_rel_a = 1'b0; hold_rel_b = 1'b0;
      chk("R6", {core_clk_en_a, core_clk_en_b}, {ba, bb});
      if (ba) hold_rel_b = 1'b1; else hold_rel_a = 1'b1;
      @(negedge clk);
      hold_rel_a = 1'b0; hold_rel_b = 1'b0;
      chk("R6", {core_clk_en_a, core_clk_en_b}, 32'd3);
      chk("R7", {core_run_a, core_run_b}, {ba, bb});
      @(negedge clk);
      chk("R7", {core_run_a, core_run_b}, 32'd3);
      repeat (3) @(negedge clk);
      chk("R6", {core_clk_en_a, core_clk_en_b, core_run_a, core_run_b}, 32'hF);
      chk("R8", boot_addr_a, xa);
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // directed corner cases
    trial(0, 0, 0, 0, 32'h081F_FFFF, 32'h0, 32'h0820_0000, 32'h0);   // limit kept / limit+1 default
    trial(1, 0, 1, 0, 32'h0, 32'h4000_0000, 32'h0, 32'h3FFF_FFFF);   // above ceiling, unmapped
    trial(1, 0, 0, 1, 32'h0, 32'h3800_FFFF, 32'h0, 32'h0001_0000);   // SRAM4 limit, ITCM+1
    trial(0, 0, 1, 1, 32'h2000_0000, 32'h0, 32'h1FF0_0000, 32'h0);   // RAM and system kept
    trial(1, 1, 1, 1, 32'h0, 32'h1FF1_FFFF, 32'h0, 32'h1000_0000);   // prot: system kept, RAM forced
    trial(0, 1, 0, 1, 32'h5000_0000, 32'h0, 32'h0800_0004, 32'h0);   // prot: unmapped forced, flash kept
    for (int n = 0; n < 40; n++)
      trial($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 1), rand_addr(), rand_addr(), rand_addr(), rand_addr());
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule